// File: doc/BRIEF.md
# Reset Cause and Control Word Register Block

This block holds a 32-bit reset cause register and a bank of plain control words behind a simple single-cycle register bus. The cause register tells software why the system last came out of reset. It also lets software request a soft power-on restart or a soft externally-initiated restart. Either request leaves the block as a one-cycle pulse on `sys_reset_req`, which the chip's reset sequencer consumes.

The block has two kinds of reset. A cold reset (`rst_n` low) is the true power-up. It clears all storage, records a power-on cause and sets the internal reset counter to one. A warm reset (`warm_rst` high, one reset event per clock) is any later system reset. A warm reset that finds the counter at zero reloads the cause register with only the power-on flag. Any other warm reset leaves the cause register as it was. Every warm reset advances the counter, which stops at its maximum value. A soft power-on request zeroes the counter, so the warm reset that follows is reported as a power-on. The control words survive warm resets.

Bus reads are combinational: `bus_rdata` is valid in the same cycle as a read strobe, and is zero when no read is strobed. Writes take effect on the clock edge. Byte offsets are the low bits of `bus_addr`. The cause register is the upper word of the 8-byte slot at 0xF020, so its address is 0xF024.

Top module: `rcs_reset_ctl`

## Requirements
- R1: After cold reset, the cause register (0xF024) reads 0x80000000, every control word reads 0 and `sys_reset_req` is low.
- R2: Bit 31 (power-on flag) and bits 28 and 27 (button flags) are write-one-to-clear. Writing 1 clears the bit. Writing 0 leaves it unchanged.
- R3: Writing 1 to bit 30 (soft power-on) or bit 29 (soft externally-initiated) sets that bit, and writing 0 does not clear it. Bits 26:0 always read 0 and are ignored on write.
- R4: A write of the cause register with bit 30 set makes `sys_reset_req` high for exactly the one cycle after the write edge. It also zeroes the reset counter, so the next warm reset loads the register with exactly 0x80000000.
- R5: A write with bit 29 set and bit 30 clear pulses `sys_reset_req` in the same way, but leaves the counter alone. The next warm reset then keeps the register contents.
- R6: A warm reset that finds the counter nonzero leaves the cause register unchanged. The counter saturates, so no number of back-to-back warm resets brings back the power-on value.
- R7: The lower word of the slot (0xF020) reads 0. Writes to it change nothing and raise no request.
- R8: Twelve control words at 0x2000 to 0x202F, selected by address bits 5:2, each read back exactly the last value written to them.
- R9: Any address outside the mapped words reads 0 and ignores writes.
- R10: A warm reset leaves the control words unchanged. A write made in a cycle where `warm_rst` is high is ignored and raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Cold (power-up) reset, active low, asynchronous |
| warm_rst | input | 1 | Warm system reset event, one event per clock it is high |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| sys_reset_req | output | 1 | One-cycle system reset request |

## Verification
The cause register is exercised with four kinds of write data:
- An all-zero word shows that no flag is cleared by a zero.
- A lone bit 31 separates write-one-to-clear from plain write.
- Bit 29 with the ignored low bits also set shows that reserved bits stay zero and that the soft externally-initiated command does not re-arm power-on detection.
- Bit 30 shows the re-arm.

A run of twenty warm resets tells a saturating counter from a wrapping one. Writes to the lower word, to an address past the control bank, and during a warm reset show that none of them reach state or the request output. Each of the twelve control words is written with a distinct value, so a wrong index shows up as a mismatch.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
   localparam int unsigned BIT_PWRON      = 31;
   localparam int unsigned BIT_SOFT_PWRON = 30;
   localparam int unsigned BIT_SOFT_EXT   = 29;
   localparam int unsigned BIT_BTN_PWRON  = 28;
   localparam int unsigned BIT_BTN_EXT    = 27;

   localparam logic [31:0] LIVE_MASK  = 32'hF800_0000;
   localparam logic [31:0] CLR_MASK   = 32'h9800_0000;
   localparam logic [31:0] SET_MASK   = 32'h6000_0000;
   localparam logic [31:0] PWRON_CODE = 32'h8000_0000;
endpackage

// File: rtl/rcs_addr_dec.sv
module rcs_addr_dec #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned NUM_CTRL = 12,
   parameter int unsigned IDX_W = 4,
   parameter logic [ADDR_W-1:0] STAT_BASE = 16'hF020,
   parameter logic [ADDR_W-1:0] CTRL_BASE = 16'h2000
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit_stat_hi,
   output logic              hit_ctrl,
   output logic [IDX_W-1:0]  ctrl_idx
);
   localparam logic [ADDR_W-1:0] CTRL_SPAN = ADDR_W'(NUM_CTRL * 4);

   logic [ADDR_W-1:0] ctrl_off;
   logic              slot_hit;

   always_comb begin
      ctrl_off    = addr - CTRL_BASE;
      slot_hit    = (addr[ADDR_W-1:3] == STAT_BASE[ADDR_W-1:3]);
      hit_stat_hi = slot_hit && addr[2];
      hit_ctrl    = (addr >= CTRL_BASE) && (ctrl_off < CTRL_SPAN);
      ctrl_idx    = ctrl_off[IDX_W+1:2];
   end
endmodule

// File: rtl/rcs_ctrl_bank.sv
module rcs_ctrl_bank #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned NUM_CTRL = 12,
   parameter int unsigned IDX_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] word_q [NUM_CTRL];

   for (genvar g = 0; g < NUM_CTRL; g++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            word_q[g] <= '0;
         end else if (wr_en && (idx == IDX_W'(g))) begin
            word_q[g] <= wdata;
         end
      end
   end

   always_comb begin
      rdata = '0;
      for (int k = 0; k < NUM_CTRL; k++) begin
         if (idx == IDX_W'(k)) rdata = word_q[k];
      end
   end
endmodule

// File: rtl/rcs_status.sv
module rcs_status
   import rcs_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W = 4,
   parameter bit CNT_SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              warm_rst,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] status_q,
   output logic [CNT_W-1:0]  cnt_q,
   output logic              req_q
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [DATA_W-1:0] wmask;
   logic [CNT_W-1:0]  cnt_next;
   logic              cmd_req;

   if (CNT_SATURATE) begin : g_sat
      assign cnt_next = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
   end else begin : g_wrap
      assign cnt_next = cnt_q + 1'b1;
   end

   always_comb begin
      wmask   = wdata & LIVE_MASK;
      cmd_req = wmask[BIT_SOFT_PWRON] | wmask[BIT_SOFT_EXT];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= PWRON_CODE;
         cnt_q    <= CNT_W'(1);
         req_q    <= 1'b0;
      end else if (warm_rst) begin
         req_q <= 1'b0;
         cnt_q <= cnt_next;
         if (cnt_q == '0) status_q <= PWRON_CODE;
      end else begin
         req_q <= wr_en && cmd_req;
         if (wr_en) begin
            status_q <= (status_q & ~(wmask & CLR_MASK)) | (wmask & SET_MASK);
            if (wmask[BIT_SOFT_PWRON]) cnt_q <= '0;
         end
      end
   end
endmodule

// File: rtl/rcs_reset_ctl.sv
module rcs_reset_ctl #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned NUM_CTRL = 12,
   parameter int unsigned CNT_W = 4,
   parameter bit CNT_SATURATE = 1'b1,
   parameter logic [ADDR_W-1:0] STAT_BASE = 16'hF020,
   parameter logic [ADDR_W-1:0] CTRL_BASE = 16'h2000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              warm_rst,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              sys_reset_req
);
   localparam int unsigned IDX_W = (NUM_CTRL > 1) ? $clog2(NUM_CTRL) : 1;

   if (DATA_W != 32) begin : g_bad_width
      $error("rcs_reset_ctl: flag positions need DATA_W of 32");
   end
   if (NUM_CTRL < 1 || NUM_CTRL > 16) begin : g_bad_count
      $error("rcs_reset_ctl: NUM_CTRL must be 1 to 16");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("rcs_reset_ctl: CNT_W must be at least 2");
   end

   logic              hit_stat_hi;
   logic              hit_ctrl;
   logic [IDX_W-1:0]  ctrl_idx;
   logic              wr_ok;
   logic [DATA_W-1:0] status_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [DATA_W-1:0] ctrl_rdata;

   assign wr_ok = bus_sel && bus_wr && !warm_rst;

   rcs_addr_dec #(
      .ADDR_W(ADDR_W), .NUM_CTRL(NUM_CTRL), .IDX_W(IDX_W),
      .STAT_BASE(STAT_BASE), .CTRL_BASE(CTRL_BASE)
   ) u_dec (
      .addr(bus_addr), .hit_stat_hi(hit_stat_hi),
      .hit_ctrl(hit_ctrl), .ctrl_idx(ctrl_idx)
   );

   rcs_status #(
      .DATA_W(DATA_W), .CNT_W(CNT_W), .CNT_SATURATE(CNT_SATURATE)
   ) u_stat (
      .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst),
      .wr_en(wr_ok && hit_stat_hi), .wdata(bus_wdata),
      .status_q(status_q), .cnt_q(cnt_q), .req_q(sys_reset_req)
   );

   rcs_ctrl_bank #(
      .DATA_W(DATA_W), .NUM_CTRL(NUM_CTRL), .IDX_W(IDX_W)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_ok && hit_ctrl),
      .idx(ctrl_idx), .wdata(bus_wdata), .rdata(ctrl_rdata)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_wr) begin
         if (hit_stat_hi)   bus_rdata = status_q;
         else if (hit_ctrl) bus_rdata = ctrl_rdata;
      end
   end
endmodule

// File: rtl/rcs_reset_ctl_chk.sv
module rcs_reset_ctl_chk #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W = 4,
   parameter logic [ADDR_W-1:0] STAT_BASE = 16'hF020
) (
   input logic              clk,
   input logic              rst_n,
   input logic              warm_rst,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              sys_reset_req,
   input logic [DATA_W-1:0] status_q,
   input logic [CNT_W-1:0]  cnt_q
);
   logic slot, wr_hi, wr_lo;
   assign slot  = bus_addr[ADDR_W-1:3] == STAT_BASE[ADDR_W-1:3];
   assign wr_hi = bus_sel && bus_wr && !warm_rst && slot && bus_addr[2];
   assign wr_lo = bus_sel && bus_wr && slot && !bus_addr[2];

   p_req_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sys_reset_req) |-> $past(wr_hi && (bus_wdata[30] || bus_wdata[29])));

   p_rearm_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hi && bus_wdata[30]) |=> (cnt_q == '0));

   p_w1c_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hi && bus_wdata[31]) |=> !status_q[31]);

   p_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      status_q[26:0] == '0);

   p_warm_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_rst && cnt_q != '0) |=> $stable(status_q));

   p_warm_por_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_rst && cnt_q == '0) |=> (status_q == 32'h8000_0000));

   p_lower_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo && !wr_hi) |=> !sys_reset_req);

   p_warm_no_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
      warm_rst |=> !sys_reset_req);
endmodule

bind rcs_reset_ctl rcs_reset_ctl_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .STAT_BASE(STAT_BASE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst), .bus_sel(bus_sel),
   .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
   .sys_reset_req(sys_reset_req), .status_q(status_q), .cnt_q(cnt_q)
);

// File: tb/sim_rcs_reset_ctl.sv
`timescale 1ns/1ps
module sim_rcs_reset_ctl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        warm_rst = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        sys_reset_req;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done = 1'b0;
   logic got_req;

   localparam logic [15:0] A_STAT = 16'hF024;
   localparam logic [15:0] A_LOW  = 16'hF020;
   localparam logic [15:0] A_CTRL = 16'h2000;

   always #2 clk = ~clk;

   rcs_reset_ctl u0 (
      .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst), .bus_sel(bus_sel),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .sys_reset_req(sys_reset_req)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %08h expected %08h", req, act, exp);
      end
   endtask

   task automatic wr(logic [15:0] a, logic [31:0] d, bit during_warm = 1'b0);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      warm_rst = during_warm;
      @(posedge clk); #1;
      got_req = sys_reset_req;
      bus_sel = 1'b0; bus_wr = 1'b0; warm_rst = 1'b0;
   endtask

   task automatic rd(logic [15:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic warm(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); warm_rst = 1'b1;
         @(posedge clk); #1; warm_rst = 1'b0;
      end
   endtask

   task automatic req_then_quiet(string req, logic exp);
      check(req, {31'b0, got_req}, {31'b0, exp});
      @(posedge clk); #1;
      check(req, {31'b0, sys_reset_req}, 32'h0);
   endtask

   function automatic logic [31:0] pat(int i);
      return 32'h5A00_00C3 ^ (32'h0101_0101 * (i + 1)) ^ (32'(i) << 12);
   endfunction

   task automatic t_cold();
      logic [31:0] d;
      rd(A_STAT, d); check("R1 cause after cold", d, 32'h8000_0000);
      rd(A_CTRL + 16'd20, d); check("R1 ctrl word after cold", d, 32'h0);
      check("R1 request after cold", {31'b0, sys_reset_req}, 32'h0);
   endtask

   task automatic t_lower();
      logic [31:0] d;
      wr(A_LOW, 32'hFFFF_FFFF);
      req_then_quiet("R7 lower write request", 1'b0);
      rd(A_LOW, d); check("R7 lower reads zero", d, 32'h0);
      rd(A_STAT, d); check("R7 cause untouched", d, 32'h8000_0000);
   endtask

   task automatic t_w1c();
      logic [31:0] d;
      wr(A_STAT, 32'h0);
      rd(A_STAT, d); check("R2 zero write keeps flag", d, 32'h8000_0000);
      wr(A_STAT, 32'h8000_0000);
      req_then_quiet("R2 clear makes no request", 1'b0);
      rd(A_STAT, d); check("R2 one clears flag", d, 32'h0);
   endtask

   task automatic t_saturate();
      logic [31:0] d;
      warm(20);
      rd(A_STAT, d); check("R6 many warm resets keep cause", d, 32'h0);
   endtask

   task automatic t_soft_ext();
      logic [31:0] d;
      wr(A_STAT, 32'h27FF_FFFF);
      req_then_quiet("R5 soft ext request pulse", 1'b1);
      rd(A_STAT, d); check("R3 soft ext flag set, low bits zero", d, 32'h2000_0000);
      warm(1);
      rd(A_STAT, d); check("R5 warm reset keeps cause", d, 32'h2000_0000);
      wr(A_STAT, 32'h0);
      rd(A_STAT, d); check("R3 zero does not clear flag", d, 32'h2000_0000);
      wr(A_STAT, 32'h1800_0000);
      req_then_quiet("R2 button clear no request", 1'b0);
      rd(A_STAT, d); check("R2 button clear no effect", d, 32'h2000_0000);
   endtask

   task automatic t_soft_pwron();
      logic [31:0] d;
      wr(A_STAT, 32'h4000_0000);
      req_then_quiet("R4 soft power-on request pulse", 1'b1);
      rd(A_STAT, d); check("R3 soft power-on flag set", d, 32'h6000_0000);
      warm(1);
      rd(A_STAT, d); check("R4 warm reset after rearm", d, 32'h8000_0000);
      warm(1);
      rd(A_STAT, d); check("R6 second warm reset keeps cause", d, 32'h8000_0000);
   endtask

   task automatic t_bank();
      logic [31:0] d;
      for (int i = 0; i < 12; i++) wr(A_CTRL + 16'(4 * i), pat(i));
      for (int i = 0; i < 12; i++) begin
         rd(A_CTRL + 16'(4 * i), d); check("R8 ctrl readback", d, pat(i));
      end
   endtask

   task automatic t_unmapped();
      logic [31:0] d;
      wr(16'h2030, 32'hDEAD_BEEF);
      rd(16'h2030, d); check("R9 past bank reads zero", d, 32'h0);
      rd(A_CTRL + 16'd44, d); check("R9 last word untouched", d, pat(11));
      rd(A_CTRL, d); check("R9 first word untouched", d, pat(0));
      rd(16'h1234, d); check("R9 unmapped reads zero", d, 32'h0);
   endtask

   task automatic t_warm_bank();
      logic [31:0] d;
      warm(3);
      rd(A_CTRL + 16'd8, d); check("R10 word kept over warm reset", d, pat(2));
      wr(A_CTRL, 32'h1111_2222, 1'b1);
      rd(A_CTRL, d); check("R10 write in warm reset ignored", d, pat(0));
      wr(A_STAT, 32'h4000_0000, 1'b1);
      req_then_quiet("R10 command in warm reset no request", 1'b0);
      rd(A_STAT, d); check("R10 cause kept", d, 32'h8000_0000);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      t_cold();
      t_lower();
      t_w1c();
      t_saturate();
      t_soft_ext();
      t_soft_pwron();
      t_bank();
      t_unmapped();
      t_warm_bank();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule